// File: doc/BRIEF.md
# Combined-Operation Byte ALU

This block is a single-stage execution unit for the family of undocumented
8-bit processor operations that merge a logic step with a shift, a subtract,
a load or a store. A sequencer outside the block fetches the operand and
works out addresses. It then presents the opcode, the accumulator, the two
index registers, the stack pointer, the operand byte, the carry and decimal
flags and the high byte of the unindexed base address, together with a
strobe. One clock edge later the block returns new register values with
write enables, new N/Z/C/V flags with a per-flag update mask, and, for the
masked-store group, a store byte and a store enable.

The block reproduces the unusual behaviour of these operations. ARR has its
own decimal-mode corrections. ANE and LXA force a set of accumulator bits
high before masking. The masked stores AND the stored value with the base
high byte plus one. Opcodes outside the supported set are reported as
illegal and change nothing.

Top module: `combo_op_unit`

## Requirements
- R1: While reset is held and after reset releases, before the first strobe, every output is zero and `out_valid` is low.
- R2: Results computed from the inputs present at a clock edge with `in_valid` high appear on the outputs after that edge, with `out_valid` high for exactly that one cycle. When `in_valid` is low, every result output holds its previous value.
- R3: Opcodes 0x0B and 0x2B write A = A & operand. N and Z update from that value, and C takes bit 7 of that value.
- R4: Opcode 0x4B takes t = A & operand, sets C to t bit 0, and writes A = t >> 1. N and Z come from the new A.
- R5: Opcode 0x6B with D clear writes A = {C, t[7:1]}, where t = A & operand. N and Z come from the new A, C becomes new A bit 6, and V becomes new A bit 6 XOR new A bit 5.
- R6: Opcode 0x6B with D set first sets N to the old C, Z from {C, t[7:1]}, and V to bit 6 of t XOR {C, t[7:1]}. It then adds 6 to the low nibble (with no carry out of the nibble) when t[3:0] + t[0] > 5. Finally, it sets C and adds 0x60 modulo 256 when ((t + (t & 0x10)) & 0x1F0) > 0x50, and clears C otherwise.
- R7: Opcode 0x8B writes A = (A | 0xEE) & X & operand. Opcode 0xAB writes both A and X with (A | 0xEE) & operand. Both update N and Z from the value written.
- R8: Opcode 0xCB writes X = ((A & X) − operand) mod 256. C is set when the subtraction needs no borrow, and N and Z come from the new X.
- R9: Opcode 0xBB writes A, X and SP all with operand & SP, and updates N and Z.
- R10: The masked stores assert `store_en` with `store_data` = source & (base_hi + 1 mod 256). The source is A & X for 0x93 and 0x9F, X for 0x9E, Y for 0x9C, and A & X for 0x9B. Opcode 0x9B also writes SP with A & X. None of these opcodes changes a flag.
- R11: `flags_out` and `flags_mask` both use bit 3 for N, bit 2 for Z, bit 1 for C and bit 0 for V. A mask bit is 1 exactly for the flags the operation defines, and any flag bit whose mask bit is 0 is driven 0.
- R12: For any opcode outside the supported set, `illegal` is high and all write enables, `flags_mask` and `store_en` are zero, as are all data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: capture results at this edge |
| opcode | input | 8 | Operation code |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| sp_in | input | 8 | Stack pointer |
| operand | input | 8 | Fetched operand byte |
| carry_in | input | 1 | Current C flag |
| decimal_in | input | 1 | Current D flag |
| base_hi | input | 8 | High byte of unindexed base address |
| out_valid | output | 1 | Results below are fresh this cycle |
| a_out | output | 8 | New accumulator |
| a_we | output | 1 | Accumulator write enable |
| x_out | output | 8 | New X |
| x_we | output | 1 | X write enable |
| sp_out | output | 8 | New stack pointer |
| sp_we | output | 1 | Stack pointer write enable |
| flags_out | output | 4 | New N,Z,C,V (bits 3..0) |
| flags_mask | output | 4 | Per-flag update mask, same bit order |
| store_data | output | 8 | Byte to store |
| store_en | output | 1 | Store data valid |
| illegal | output | 1 | Opcode not supported |

## Verification
Every result is due one rising edge after the strobed edge, and `out_valid` marks that cycle. The driver applies inputs on a falling edge and queues the item it predicts. The monitor samples on the next falling edge after `out_valid` rises, half a period after the capturing edge, so no check falls on an edge. The hold behaviour is checked separately: after the strobe drops, the bench waits several idle cycles and confirms that the last queued result is still on the outputs.

// File: rtl/combo_op_pkg.sv
package combo_op_pkg;

   localparam int BYTE_W = 8;

   // flag bit positions shared by flags_out and flags_mask
   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;
   localparam int FLAG_W = 4;

   typedef enum logic [3:0] {
      K_NONE,
      K_ANDC,   // and, carry from sign
      K_ANDSR,  // and then shift right
      K_ANDRR,  // and then rotate right with fixups
      K_MAGA,   // magic-constant and into A
      K_MAGAX,  // magic-constant and into A and X
      K_AXSUB,  // (A&X) minus operand into X
      K_SPAND,  // operand & SP into A, X, SP
      K_STAX,   // masked store of A&X
      K_STX,    // masked store of X
      K_STY,    // masked store of Y
      K_STSP    // masked store of A&X, SP loaded
   } op_kind_e;

   typedef struct packed {
      logic [BYTE_W-1:0] a;
      logic              a_we;
      logic [BYTE_W-1:0] x;
      logic              x_we;
      logic [BYTE_W-1:0] sp;
      logic              sp_we;
      logic [FLAG_W-1:0] flags;
      logic [FLAG_W-1:0] mask;
      logic [BYTE_W-1:0] st;
      logic              st_en;
      logic              illegal;
   } result_t;

endpackage

// File: rtl/combo_decode.sv
module combo_decode
   import combo_op_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic [OPW-1:0] opcode,
   output op_kind_e       kind
);

   if (OPW != 8) begin : g_bad_opw
      $error("combo_decode: opcode width must be 8");
   end

   always_comb begin
      unique case (opcode)
         8'h0B, 8'h2B: kind = K_ANDC;
         8'h4B:        kind = K_ANDSR;
         8'h6B:        kind = K_ANDRR;
         8'h8B:        kind = K_MAGA;
         8'hAB:        kind = K_MAGAX;
         8'hCB:        kind = K_AXSUB;
         8'hBB:        kind = K_SPAND;
         8'h93, 8'h9F: kind = K_STAX;
         8'h9E:        kind = K_STX;
         8'h9C:        kind = K_STY;
         8'h9B:        kind = K_STSP;
         default:      kind = K_NONE;
      endcase
   end

endmodule

// File: rtl/combo_arr.sv
module combo_arr #(
   parameter int DW         = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic [DW-1:0] t_in,
   input  logic          c_in,
   input  logic          d_in,
   output logic [DW-1:0] r_out,
   output logic          n_out,
   output logic          z_out,
   output logic          c_out,
   output logic          v_out
);

   localparam int NIB = DW / 2;

   if (DW != 8) begin : g_bad_dw
      $error("combo_arr: nibble fixups are defined for 8-bit data only");
   end

   logic [DW-1:0] rot;
   assign rot = {c_in, t_in[DW-1:1]};

   // binary-mode results
   logic bin_c, bin_v;
   assign bin_c = rot[DW-2];
   assign bin_v = rot[DW-2] ^ rot[DW-3];

   if (DECIMAL_EN) begin : g_dec
      logic [NIB:0]     lo_sum;
      logic             lo_fix;
      logic [DW-1:0]    r_lo;
      logic [DW:0]      hi_sum;
      logic             hi_fix;
      logic [NIB-1:0]   lo_add;

      assign lo_sum = {1'b0, t_in[NIB-1:0]} + {{NIB{1'b0}}, t_in[0]};
      assign lo_fix = lo_sum > (NIB+1)'(5);
      assign lo_add = rot[NIB-1:0] + NIB'(6);
      assign r_lo   = lo_fix ? {rot[DW-1:NIB], lo_add} : rot;
      assign hi_sum = {1'b0, t_in} + {1'b0, t_in & DW'(8'h10)};
      assign hi_fix = (hi_sum & (DW+1)'(9'h1F0)) > (DW+1)'(9'h050);

      always_comb begin
         if (d_in) begin
            n_out = c_in;
            z_out = (rot == '0);
            v_out = t_in[DW-2] ^ rot[DW-2];
            c_out = hi_fix;
            r_out = hi_fix ? r_lo + DW'(8'h60) : r_lo;
         end else begin
            n_out = rot[DW-1];
            z_out = (rot == '0);
            v_out = bin_v;
            c_out = bin_c;
            r_out = rot;
         end
      end
   end else begin : g_bin
      assign n_out = rot[DW-1];
      assign z_out = (rot == '0);
      assign v_out = bin_v;
      assign c_out = bin_c;
      assign r_out = rot;
   end

endmodule

// File: rtl/combo_storemask.sv
module combo_storemask
   import combo_op_pkg::*;
#(
   parameter int DW = 8
) (
   input  op_kind_e      kind,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] base_hi,
   output logic [DW-1:0] data,
   output logic          active
);

   logic [DW-1:0] hi_inc, src;

   assign hi_inc = base_hi + DW'(1);

   always_comb begin
      active = 1'b1;
      unique case (kind)
         K_STAX, K_STSP: src = a_in & x_in;
         K_STX:          src = x_in;
         K_STY:          src = y_in;
         default: begin
            src    = '0;
            active = 1'b0;
         end
      endcase
   end

   assign data = src & hi_inc;

endmodule

// File: rtl/combo_exec.sv
module combo_exec
   import combo_op_pkg::*;
#(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] MAGIC      = 8'hEE,
   parameter bit            DECIMAL_EN = 1'b1
) (
   input  op_kind_e      kind,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] operand,
   input  logic          carry_in,
   input  logic          decimal_in,
   input  logic [DW-1:0] base_hi,
   output result_t       res
);

   localparam logic [FLAG_W-1:0] M_NZ   = FLAG_W'((1 << FLAG_N) | (1 << FLAG_Z));
   localparam logic [FLAG_W-1:0] M_NZC  = M_NZ | FLAG_W'(1 << FLAG_C);
   localparam logic [FLAG_W-1:0] M_ALL  = M_NZC | FLAG_W'(1 << FLAG_V);

   if (DW != BYTE_W) begin : g_bad_dw
      $error("combo_exec: DW must equal the package byte width");
   end

   logic [DW-1:0] and_ao, and_ax, mag_a, mag_ax, sp_and;
   logic [DW:0]   sub_full;
   logic [DW-1:0] arr_r, st_data;
   logic          arr_n, arr_z, arr_c, arr_v, st_act;

   assign and_ao   = a_in & operand;
   assign and_ax   = a_in & x_in;
   assign mag_a    = (a_in | MAGIC) & x_in & operand;
   assign mag_ax   = (a_in | MAGIC) & operand;
   assign sp_and   = operand & sp_in;
   assign sub_full = {1'b0, and_ax} - {1'b0, operand};

   combo_arr #(.DW(DW), .DECIMAL_EN(DECIMAL_EN)) u_arr (
      .t_in  (and_ao),
      .c_in  (carry_in),
      .d_in  (decimal_in),
      .r_out (arr_r),
      .n_out (arr_n),
      .z_out (arr_z),
      .c_out (arr_c),
      .v_out (arr_v)
   );

   combo_storemask #(.DW(DW)) u_st (
      .kind    (kind),
      .a_in    (a_in),
      .x_in    (x_in),
      .y_in    (y_in),
      .base_hi (base_hi),
      .data    (st_data),
      .active  (st_act)
   );

   function automatic logic [FLAG_W-1:0] nz_of(input logic [DW-1:0] v);
      logic [FLAG_W-1:0] f;
      f         = '0;
      f[FLAG_N] = v[DW-1];
      f[FLAG_Z] = (v == '0);
      return f;
   endfunction

   always_comb begin
      res = '0;
      unique case (kind)
         K_ANDC: begin
            res.a = and_ao; res.a_we = 1'b1;
            res.flags = nz_of(and_ao);
            res.flags[FLAG_C] = and_ao[DW-1];
            res.mask = M_NZC;
         end
         K_ANDSR: begin
            res.a = and_ao >> 1; res.a_we = 1'b1;
            res.flags = nz_of(and_ao >> 1);
            res.flags[FLAG_C] = and_ao[0];
            res.mask = M_NZC;
         end
         K_ANDRR: begin
            res.a = arr_r; res.a_we = 1'b1;
            res.flags[FLAG_N] = arr_n;
            res.flags[FLAG_Z] = arr_z;
            res.flags[FLAG_C] = arr_c;
            res.flags[FLAG_V] = arr_v;
            res.mask = M_ALL;
         end
         K_MAGA: begin
            res.a = mag_a; res.a_we = 1'b1;
            res.flags = nz_of(mag_a);
            res.mask = M_NZ;
         end
         K_MAGAX: begin
            res.a = mag_ax; res.a_we = 1'b1;
            res.x = mag_ax; res.x_we = 1'b1;
            res.flags = nz_of(mag_ax);
            res.mask = M_NZ;
         end
         K_AXSUB: begin
            res.x = sub_full[DW-1:0]; res.x_we = 1'b1;
            res.flags = nz_of(sub_full[DW-1:0]);
            res.flags[FLAG_C] = ~sub_full[DW];
            res.mask = M_NZC;
         end
         K_SPAND: begin
            res.a = sp_and; res.a_we = 1'b1;
            res.x = sp_and; res.x_we = 1'b1;
            res.sp = sp_and; res.sp_we = 1'b1;
            res.flags = nz_of(sp_and);
            res.mask = M_NZ;
         end
         K_STAX, K_STX, K_STY: begin
            res.st = st_data; res.st_en = st_act;
         end
         K_STSP: begin
            res.st = st_data; res.st_en = st_act;
            res.sp = and_ax; res.sp_we = 1'b1;
         end
         default: res.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/combo_op_unit.sv
module combo_op_unit
   import combo_op_pkg::*;
#(
   parameter int          DW         = 8,
   parameter logic [7:0]  MAGIC      = 8'hEE,
   parameter bit          DECIMAL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    opcode,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] operand,
   input  logic          carry_in,
   input  logic          decimal_in,
   input  logic [DW-1:0] base_hi,
   output logic          out_valid,
   output logic [DW-1:0] a_out,
   output logic          a_we,
   output logic [DW-1:0] x_out,
   output logic          x_we,
   output logic [DW-1:0] sp_out,
   output logic          sp_we,
   output logic [3:0]    flags_out,
   output logic [3:0]    flags_mask,
   output logic [DW-1:0] store_data,
   output logic          store_en,
   output logic          illegal
);

   if (DW != BYTE_W) begin : g_bad_dw
      $error("combo_op_unit: only byte-wide data is supported");
   end

   op_kind_e kind;
   result_t  res_d, res_q;
   logic     vld_q;

   combo_decode #(.OPW(8)) u_dec (
      .opcode (opcode),
      .kind   (kind)
   );

   combo_exec #(.DW(DW), .MAGIC(MAGIC), .DECIMAL_EN(DECIMAL_EN)) u_exec (
      .kind       (kind),
      .a_in       (a_in),
      .x_in       (x_in),
      .y_in       (y_in),
      .sp_in      (sp_in),
      .operand    (operand),
      .carry_in   (carry_in),
      .decimal_in (decimal_in),
      .base_hi    (base_hi),
      .res        (res_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) res_q <= res_d;
      end
   end

   assign out_valid  = vld_q;
   assign a_out      = res_q.a;
   assign a_we       = res_q.a_we;
   assign x_out      = res_q.x;
   assign x_we       = res_q.x_we;
   assign sp_out     = res_q.sp;
   assign sp_we      = res_q.sp_we;
   assign flags_out  = res_q.flags;
   assign flags_mask = res_q.mask;
   assign store_data = res_q.st;
   assign store_en   = res_q.st_en;
   assign illegal    = res_q.illegal;

endmodule

// File: rtl/combo_op_unit_chk.sv
module combo_op_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [7:0] opcode,
   input logic [7:0] base_hi,
   input logic       out_valid,
   input logic [7:0] a_out,
   input logic       a_we,
   input logic [7:0] x_out,
   input logic       x_we,
   input logic [7:0] sp_out,
   input logic       sp_we,
   input logic [3:0] flags_out,
   input logic [3:0] flags_mask,
   input logic [7:0] store_data,
   input logic       store_en,
   input logic       illegal
);

   // base high byte plus one, captured alongside each strobe
   logic [7:0] hi_plus_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_plus_q <= 8'h00;
      else if (in_valid) hi_plus_q <= base_hi + 8'd1;
   end

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(a_out) && $stable(x_out) && $stable(sp_out)
                     && $stable(store_data) && $stable(flags_out)));

   assert_anc_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 8'h2B) |=> (flags_out[1] == a_out[7]));

   assert_las_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && a_we && x_we) |-> (a_out == sp_out && x_out == sp_out));

   assert_store_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |-> ((store_data & ~hi_plus_q) == 8'h00 && flags_mask == 4'h0));

   assert_unmasked_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((flags_out & ~flags_mask) == 4'h0));

   assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!a_we && !x_we && !sp_we && !store_en && flags_mask == 4'h0));

   assert_jam_flagged_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 8'h02) |=> illegal);

endmodule

bind combo_op_unit combo_op_unit_chk u_chk (.*);

// File: tb/combo_op_unit_test.sv
module combo_op_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] opcode = 8'h00, a_in = 8'h00, x_in = 8'h00, y_in = 8'h00;
   logic [7:0] sp_in = 8'h00, operand = 8'h00, base_hi = 8'h00;
   logic       carry_in = 1'b0, decimal_in = 1'b0;

   logic       out_valid, a_we, x_we, sp_we, store_en, illegal;
   logic [7:0] a_out, x_out, sp_out, store_data;
   logic [3:0] flags_out, flags_mask;

   always #5 clk = ~clk;

   combo_op_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .a_in(a_in), .x_in(x_in), .y_in(y_in), .sp_in(sp_in),
      .operand(operand), .carry_in(carry_in), .decimal_in(decimal_in),
      .base_hi(base_hi), .out_valid(out_valid), .a_out(a_out), .a_we(a_we),
      .x_out(x_out), .x_we(x_we), .sp_out(sp_out), .sp_we(sp_we),
      .flags_out(flags_out), .flags_mask(flags_mask),
      .store_data(store_data), .store_en(store_en), .illegal(illegal)
   );

   // {a, a_we, x, x_we, sp, sp_we, flags, mask, st, st_en, illegal}
   typedef logic [44:0] exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fail = 0;
   exp_t  last_exp = '0;
   bit    done = 1'b0;

   function automatic exp_t dut_now();
      return {a_out, a_we, x_out, x_we, sp_out, sp_we, flags_out, flags_mask,
              store_data, store_en, illegal};
   endfunction

   function automatic exp_t model(input logic [7:0] op, a, x, y, sp, m,
                                  input logic c, d, input logic [7:0] hi);
      logic [7:0] na = 8'h00, nx = 8'h00, ns = 8'h00, st = 8'h00;
      logic       wa = 0, wx = 0, ws = 0, se = 0, il = 0;
      logic       fn = 0, fz = 0, fc = 0, fv = 0;
      logic [3:0] mk = 4'h0;
      int tt, r, diff;
      case (op)
         8'h0B, 8'h2B: begin   // R3
            na = a & m; wa = 1; fn = na[7]; fz = (na == 0); fc = na[7]; mk = 4'b1110;
         end
         8'h4B: begin          // R4
            tt = a & m; fc = tt[0]; na = 8'(tt / 2); wa = 1;
            fn = na[7]; fz = (na == 0); mk = 4'b1110;
         end
         8'h6B: begin          // R5 / R6
            tt = a & m; r = (tt / 2) + (c ? 128 : 0); wa = 1; mk = 4'b1111;
            if (!d) begin
               na = 8'(r); fn = na[7]; fz = (na == 0); fc = na[6]; fv = na[6] ^ na[5];
            end else begin
               fn = c; fz = (r == 0); fv = ((tt ^ r) >> 6) & 1;
               if ((tt % 16) + (tt % 2) > 5) r = (r & 'hF0) | ((r + 6) & 'h0F);
               if (((tt + (tt & 'h10)) & 'h1F0) > 'h50) begin
                  fc = 1; r = (r + 'h60) % 256;
               end else fc = 0;
               na = 8'(r);
            end
         end
         8'h8B: begin          // R7
            na = (a | 8'hEE) & x & m; wa = 1; fn = na[7]; fz = (na == 0); mk = 4'b1100;
         end
         8'hAB: begin          // R7
            na = (a | 8'hEE) & m; nx = na; wa = 1; wx = 1;
            fn = na[7]; fz = (na == 0); mk = 4'b1100;
         end
         8'hCB: begin          // R8
            diff = int'(a & x) - int'(m); fc = (diff >= 0);
            nx = 8'((diff + 256) % 256); wx = 1; fn = nx[7]; fz = (nx == 0); mk = 4'b1110;
         end
         8'hBB: begin          // R9
            na = m & sp; nx = na; ns = na; wa = 1; wx = 1; ws = 1;
            fn = na[7]; fz = (na == 0); mk = 4'b1100;
         end
         8'h93, 8'h9F: begin st = a & x & 8'(hi + 1); se = 1; end   // R10
         8'h9E:        begin st = x & 8'(hi + 1); se = 1; end
         8'h9C:        begin st = y & 8'(hi + 1); se = 1; end
         8'h9B:        begin st = a & x & 8'(hi + 1); se = 1; ns = a & x; ws = 1; end
         default: il = 1;      // R12
      endcase
      return {na, wa, nx, wx, ns, ws, {fn, fz, fc, fv} & mk, mk, st, se, il};
   endfunction

   task automatic send(input logic [7:0] op, a, x, y, sp, m,
                       input logic c, d, input logic [7:0] hi, input string tag);
      opcode = op; a_in = a; x_in = x; y_in = y; sp_in = sp; operand = m;
      carry_in = c; decimal_in = d; base_hi = hi; in_valid = 1'b1;
      last_exp = model(op, a, x, y, sp, m, c, d, hi);
      exp_q.push_back(last_exp);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   // monitor: results are due one rising edge after the strobe
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            exp_t  e;
            string t;
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R2 unexpected out_valid: actual=%h expected=no result", dut_now());
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (dut_now() !== e) begin
                  n_fail++;
                  $display("FAIL %s: actual=%h expected=%h", t, dut_now(), e);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog expired: actual=hung expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      logic [7:0]  ops [15];
      ops = '{8'h0B, 8'h2B, 8'h4B, 8'h6B, 8'h8B, 8'hAB, 8'hCB, 8'hBB,
              8'h93, 8'h9F, 8'h9E, 8'h9C, 8'h9B, 8'hEA, 8'h12};
      lfsr = 32'hACE1_2468;

      repeat (3) @(negedge clk);
      n_checks++;   // R1: outputs cleared during reset
      if ({out_valid, dut_now()} !== '0) begin
         n_fail++;
         $display("FAIL R1 in reset: actual=%h expected=0", {out_valid, dut_now()});
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      n_checks++;   // R1: still cleared after release, no strobe yet
      if ({out_valid, dut_now()} !== '0) begin
         n_fail++;
         $display("FAIL R1 after release: actual=%h expected=0", {out_valid, dut_now()});
      end

      // directed cases
      send(8'h0B, 8'hF0, 0, 0, 0, 8'h8F, 0, 0, 0, "R3 anc sign");
      send(8'h2B, 8'h0F, 0, 0, 0, 8'hF0, 1, 0, 0, "R3 anc zero");
      send(8'h4B, 8'hFF, 0, 0, 0, 8'h03, 0, 0, 0, "R4 asr carry");
      send(8'h4B, 8'h01, 0, 0, 0, 8'h01, 0, 0, 0, "R4 asr zero");
      send(8'h6B, 8'hFF, 0, 0, 0, 8'hFF, 1, 0, 0, "R5 arr bin c1");
      send(8'h6B, 8'hC0, 0, 0, 0, 8'hFF, 0, 0, 0, "R5 arr bin v");
      send(8'h6B, 8'h00, 0, 0, 0, 8'hFF, 0, 0, 0, "R5 arr bin zero");
      send(8'h6B, 8'hFF, 0, 0, 0, 8'hFF, 1, 1, 0, "R6 arr dec both fixups");
      send(8'h6B, 8'h05, 0, 0, 0, 8'hFF, 0, 1, 0, "R6 arr dec low fixup");
      send(8'h6B, 8'h40, 0, 0, 0, 8'hFF, 0, 1, 0, "R6 arr dec v only");
      send(8'h6B, 8'h00, 0, 0, 0, 8'h00, 1, 1, 0, "R6 arr dec n from c");
      send(8'h8B, 8'h00, 8'hFF, 0, 0, 8'hFF, 0, 0, 0, "R7 ane magic");
      send(8'hAB, 8'h01, 8'h55, 0, 0, 8'hFF, 0, 0, 0, "R7 lxa magic");
      send(8'hCB, 8'hFF, 8'h10, 0, 0, 8'h10, 0, 0, 0, "R8 sbx equal");
      send(8'hCB, 8'h0F, 8'h0F, 0, 0, 8'h10, 0, 0, 0, "R8 sbx borrow");
      send(8'hBB, 0, 0, 0, 8'h3C, 8'hF6, 0, 0, 0, "R9 las");
      send(8'h93, 8'hF3, 8'h3F, 0, 0, 0, 0, 0, 8'h0F, "R10 sha ind");
      send(8'h9F, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, 8'hFF, "R10 sha wrap");
      send(8'h9E, 0, 8'hAA, 0, 0, 0, 0, 0, 8'h7F, "R10 shx");
      send(8'h9C, 0, 0, 8'h5A, 0, 0, 0, 0, 8'h02, "R10 shy");
      send(8'h9B, 8'hF0, 8'h3C, 0, 8'h77, 0, 0, 0, 8'h30, "R10 shs sp");
      send(8'h02, 8'h11, 8'h22, 0, 0, 8'h33, 1, 1, 0, "R12 jam");
      send(8'hEA, 8'h11, 8'h22, 0, 0, 8'h33, 0, 0, 0, "R12 nop");

      // pseudo-random sweep over supported and unsupported codes (R11 masks)
      for (int i = 0; i < 400; i++) begin
         logic [7:0] b0, b1, b2, b3;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         b0 = lfsr[7:0]; b1 = lfsr[15:8]; b2 = lfsr[23:16]; b3 = lfsr[31:24];
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         send(ops[i % 15], b0, b1, b2, b3, b1 ^ b2, lfsr[3], lfsr[9],
              b0 ^ b3, "R11 sweep");
      end

      // R2: strobe low, outputs hold the last result
      in_valid = 1'b0;
      opcode = 8'h0B; a_in = 8'hFF; operand = 8'hFF;
      repeat (4) @(negedge clk);
      n_checks++;
      if (dut_now() !== last_exp || out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R2 hold: actual=%h expected=%h", dut_now(), last_exp);
      end
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R2 missing results: actual=%0d pending expected=0", exp_q.size());
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule